// File: doc/BRIEF.md
# Packed Byte Arithmetic Shifter with Rounding

This block is one SIMD execution slice. It takes one 32-bit instruction word and one 32-bit source operand. The operand holds four signed 8-bit lanes. A small decoder recognises two instruction forms, a truncating form and a rounding form, and extracts the shift amount and both register indices from the instruction word.

Every lane is shifted right arithmetically by the same amount. The rounding form adds one at the most significant discarded bit before it truncates. Because that sum is formed in a 9-bit intermediate, it never wraps.

The four lane results are packed into the low 32 bits of a 64-bit result. The sign bit of the top lane is copied into all of the upper 32 bits. An optional output register adds one cycle of latency and carries a valid flag along with the data. The register file, exception handling and any unit-enable gating are outside this block.

Top module: `pbs_shifter`

## Requirements
- R1: In the truncating form, each lane (bits 31:24, 23:16, 15:8, 7:0) becomes floor(x / 2^sa), where x is the lane as a signed byte and sa is an unsigned amount from 0 to 7. The sign of each lane result equals the sign of its input lane.
- R2: In the rounding form with sa nonzero, each lane becomes floor((x + 2^(sa-1)) / 2^sa), so a value exactly halfway rounds up. The result is never saturated (for example, 0x7F with sa=1 gives 0x40).
- R3: In the rounding form with sa equal to zero, every lane passes through unchanged.
- R4: Bits 63:32 of the result are all copies of result bit 31.
- R5: The decode hit flag is high only when all of these hold: instr[31:26]=011111, instr[25:24]=00, instr[5:0]=010011, and instr[10:6] is either 00100 (truncating form) or 00101 (rounding form). Any other word gives hit low.
- R6: The shift amount is taken from instr[23:21]. The source register index instr[20:16] is reported on out_src, and the destination index instr[15:11] is reported on out_dst.
- R7: With REG_OUT=1, out_valid is in_valid delayed by exactly one clock. The outputs of an accepted input appear one clock after it. While in_valid is low, out_result holds its value.
- R8: A synchronous active-high reset clears out_valid, out_hit, out_src, out_dst and out_result to zero.
- R9: out_hit is never high while out_valid is low, even if the instruction word decodes as a hit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Instruction and operand are presented this cycle |
| instr | input | 32 | Instruction word |
| src_data | input | 32 | Source operand, four signed byte lanes |
| out_valid | output | 1 | Result qualifier |
| out_hit | output | 1 | Instruction decoded as one of the two shift forms |
| out_src | output | 5 | Source register index field |
| out_dst | output | 5 | Destination register index field |
| out_result | output | 64 | Sign-extended packed lane result |

## Verification
The bench builds the block with REG_OUT=1. This brings the one-cycle latency, the valid tracking and the hold-while-idle behaviour into reach of both the bench and the clocked assertions. The combinational variant is not exercised. Every stimulus word is run for all eight shift amounts in both forms. The words include lanes of 0x7F, 0x80, 0xFF and 0x00, and lanes whose highest discarded bit is one. Their results are compared against a reference that rounds by signed floor division.

// File: rtl/pbs_pkg.sv
package pbs_pkg;
    localparam int LANE_W  = 8;
    localparam int LANES   = 4;
    localparam int SH_W    = 3;
    localparam int REG_W   = 5;
    localparam int WORD_W  = LANE_W * LANES;
    localparam int RES_W   = 2 * WORD_W;

    localparam logic [5:0] MAJOR_OP = 6'b011111;
    localparam logic [5:0] FUNC_OP  = 6'b010011;

    typedef enum logic [4:0] {
        SUB_TRUNC = 5'b00100,
        SUB_ROUND = 5'b00101
    } sub_op_e;

    typedef logic [LANE_W-1:0] lane_t;

    typedef struct packed {
        logic             hit;
        logic             rnd;
        logic [SH_W-1:0]  amt;
        logic [REG_W-1:0] src;
        logic [REG_W-1:0] dst;
    } dec_t;

    function automatic logic [RES_W-1:0] widen(input logic [WORD_W-1:0] packed_lanes);
        return {{WORD_W{packed_lanes[WORD_W-1]}}, packed_lanes};
    endfunction
endpackage

// File: rtl/pbs_decode.sv
module pbs_decode
    import pbs_pkg::*;
(
    input  logic [31:0] instr,
    output dec_t        dec
);
    logic [5:0] major;
    logic [1:0] zero_f;
    logic [4:0] sub_f;
    logic [5:0] func_f;
    logic       is_trunc;
    logic       is_round;

    always_comb begin
        major    = instr[31:26];
        zero_f   = instr[25:24];
        sub_f    = instr[10:6];
        func_f   = instr[5:0];
        is_trunc = (sub_f == SUB_TRUNC);
        is_round = (sub_f == SUB_ROUND);
        dec.hit  = (major == MAJOR_OP) && (func_f == FUNC_OP) &&
                   (zero_f == 2'b00) && (is_trunc || is_round);
        dec.rnd  = is_round;
        dec.amt  = instr[23:21];
        dec.src  = instr[20:16];
        dec.dst  = instr[15:11];
    end
endmodule

// File: rtl/pbs_lane.sv
module pbs_lane
    import pbs_pkg::*;
(
    input  lane_t           lane_i,
    input  logic [SH_W-1:0] amt,
    input  logic            rnd,
    output lane_t           lane_o
);
    logic signed [LANE_W:0]   ext;
    logic signed [LANE_W:0]   sum;
    logic signed [LANE_W-1:0] trunc;

    always_comb begin
        trunc = $signed(lane_i) >>> amt;
        ext   = $signed({lane_i, 1'b0}) >>> amt;
        sum   = ext + 9'sd1;
        if (!rnd)
            lane_o = lane_t'(trunc);
        else if (amt == '0)
            lane_o = lane_i;
        else
            lane_o = sum[LANE_W:1];
    end

    always_comb begin
        if (!$isunknown({lane_i, amt, rnd})) begin
            if (rnd && amt == '0)
                AST_RND_ZERO_PASS: assert (lane_o == lane_i); // R3
            if (!rnd)
                AST_TRUNC_SIGN: assert (lane_o[LANE_W-1] == lane_i[LANE_W-1]); // R1
        end
    end
endmodule

// File: rtl/pbs_outreg.sv
module pbs_outreg
    import pbs_pkg::*;
#(
    parameter bit REG_OUT = 1'b1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             v_i,
    input  logic             hit_i,
    input  logic [REG_W-1:0] src_i,
    input  logic [REG_W-1:0] dst_i,
    input  logic [RES_W-1:0] res_i,
    output logic             v_o,
    output logic             hit_o,
    output logic [REG_W-1:0] src_o,
    output logic [REG_W-1:0] dst_o,
    output logic [RES_W-1:0] res_o
);
    generate
        if (REG_OUT) begin : g_reg
            always_ff @(posedge clk) begin
                if (rst) begin
                    v_o   <= 1'b0;
                    hit_o <= 1'b0;
                    src_o <= '0;
                    dst_o <= '0;
                    res_o <= '0;
                end else begin
                    v_o   <= v_i;
                    hit_o <= hit_i;
                    if (v_i) begin
                        src_o <= src_i;
                        dst_o <= dst_i;
                        res_o <= res_i;
                    end
                end
            end

            AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
                v_i |=> v_o); // R7
            AST_IDLE_DROPS: assert property (@(posedge clk) disable iff (rst)
                !v_i |=> !v_o); // R7
            AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
                !v_i |=> $stable(res_o)); // R7
        end else begin : g_comb
            always_comb begin
                v_o   = v_i;
                hit_o = hit_i;
                src_o = src_i;
                dst_o = dst_i;
                res_o = res_i;
            end
        end
    endgenerate
endmodule

// File: rtl/pbs_shifter.sv
module pbs_shifter
    import pbs_pkg::*;
#(
    parameter bit REG_OUT = 1'b1
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        in_valid,
    input  logic [31:0] instr,
    input  logic [31:0] src_data,
    output logic        out_valid,
    output logic        out_hit,
    output logic [4:0]  out_src,
    output logic [4:0]  out_dst,
    output logic [63:0] out_result
);
    dec_t              dec;
    lane_t [LANES-1:0] lanes_out;
    logic [RES_W-1:0]  res_comb;
    logic              hit_q;

    pbs_decode u_dec (
        .instr (instr),
        .dec   (dec)
    );

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        pbs_lane u_lane (
            .lane_i (src_data[g*LANE_W +: LANE_W]),
            .amt    (dec.amt),
            .rnd    (dec.rnd),
            .lane_o (lanes_out[g])
        );
    end

    assign res_comb = widen(lanes_out);
    assign hit_q    = dec.hit & in_valid;

    pbs_outreg #(.REG_OUT(REG_OUT)) u_out (
        .clk   (clk),
        .rst   (rst),
        .v_i   (in_valid),
        .hit_i (hit_q),
        .src_i (dec.src),
        .dst_i (dec.dst),
        .res_i (res_comb),
        .v_o   (out_valid),
        .hit_o (out_hit),
        .src_o (out_src),
        .dst_o (out_dst),
        .res_o (out_result)
    );

    AST_HIT_NEEDS_VALID: assert property (@(posedge clk) disable iff (rst)
        out_hit |-> out_valid); // R9
    AST_SIGN_FILL: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> out_result[63:32] == {32{out_result[31]}}); // R4
endmodule

// File: tb/sim_pbs_shifter.sv
`timescale 1ns/1ps
module sim_pbs_shifter;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [31:0] instr = '0;
    logic [31:0] src_data = '0;
    logic        out_valid;
    logic        out_hit;
    logic [4:0]  out_src;
    logic [4:0]  out_dst;
    logic [63:0] out_result;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #2 clk = ~clk;

    pbs_shifter #(.REG_OUT(1'b1)) u0 (
        .clk(clk), .rst(rst), .in_valid(in_valid), .instr(instr),
        .src_data(src_data), .out_valid(out_valid), .out_hit(out_hit),
        .out_src(out_src), .out_dst(out_dst), .out_result(out_result)
    );

    localparam int NW = 8;
    localparam logic [31:0] WORDS [NW] = '{
        32'h7F80FF00, 32'hFF007F80, 32'h12345678, 32'h9ABCDEF0,
        32'h55AA33CC, 32'h81C0E0F0, 32'h7E3F1F0F, 32'h06030201
    };

    function automatic logic [31:0] mk(input bit rnd, input int sa,
                                       input int rs, input int rd);
        return {6'b011111, 2'b00, 3'(sa), 5'(rs), 5'(rd),
                (rnd ? 5'b00101 : 5'b00100), 6'b010011};
    endfunction

    function automatic int fdiv(input int n, input int d);
        int q;
        q = n / d;
        if ((n % d) != 0 && n < 0) q = q - 1;
        return q;
    endfunction

    function automatic logic [63:0] model(input logic [31:0] w, input bit rnd, input int sa);
        logic [31:0] lo;
        for (int k = 0; k < 4; k++) begin
            int x, r;
            x = int'($signed(w[k*8 +: 8]));
            if (rnd && sa == 0) r = x;
            else if (rnd)       r = fdiv(x + (1 << (sa - 1)), 1 << sa);
            else                r = fdiv(x, 1 << sa);
            lo[k*8 +: 8] = 8'(r);
        end
        return {{32{lo[31]}}, lo};
    endfunction

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic issue(input logic v, input logic [31:0] i, input logic [31:0] d);
        @(negedge clk);
        in_valid = v; instr = i; src_data = d;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk("R8 reset valid", {63'b0, out_valid}, 64'd0);
        chk("R8 reset hit", {63'b0, out_hit}, 64'd0);
        chk("R8 reset result", out_result, 64'd0);
        rst = 1'b0;

        for (int w = 0; w < NW; w++)
            for (int r = 0; r < 2; r++)
                for (int s = 0; s < 8; s++) begin
                    issue(1'b1, mk(r[0], s, 3, 12), WORDS[w]);
                    chk(r[0] ? (s == 0 ? "R3 round sa0" : "R2 round") : "R1 trunc",
                        out_result, model(WORDS[w], r[0], s));
                    chk("R5 hit", {63'b0, out_hit}, 64'd1);
                end

        issue(1'b1, mk(1'b1, 1, 0, 0), 32'h7F80FF00);
        chk("R2 hand", out_result, 64'h00000000_40C00000);
        issue(1'b1, mk(1'b0, 7, 0, 0), 32'h7F80FF00);
        chk("R1 hand", out_result, 64'h00000000_00FFFF00);
        issue(1'b1, mk(1'b0, 0, 0, 0), 32'h80000000);
        chk("R4 sign fill", out_result, 64'hFFFFFFFF_80000000);
        issue(1'b1, mk(1'b1, 0, 0, 0), 32'h80FF7F01);
        chk("R3 hand", out_result, 64'hFFFFFFFF_80FF7F01);

        issue(1'b1, mk(1'b1, 2, 17, 9), 32'h0);
        chk("R6 src", {59'b0, out_src}, 64'd17);
        chk("R6 dst", {59'b0, out_dst}, 64'd9);

        issue(1'b1, mk(1'b0, 1, 1, 1) ^ 32'h8000_0000, 32'h0);
        chk("R5 bad major", {63'b0, out_hit}, 64'd0);
        issue(1'b1, mk(1'b0, 1, 1, 1) ^ 32'h0000_0001, 32'h0);
        chk("R5 bad func", {63'b0, out_hit}, 64'd0);
        issue(1'b1, mk(1'b0, 1, 1, 1) ^ 32'h0000_0080, 32'h0);
        chk("R5 bad sub", {63'b0, out_hit}, 64'd0);
        issue(1'b1, mk(1'b0, 1, 1, 1) | 32'h0100_0000, 32'h0);
        chk("R5 zero field", {63'b0, out_hit}, 64'd0);

        issue(1'b1, mk(1'b0, 0, 0, 0), 32'h1234_5678);
        chk("R7 valid after 1", {63'b0, out_valid}, 64'd1);
        issue(1'b0, mk(1'b0, 3, 0, 0), 32'hFFFF_FFFF);
        chk("R7 valid drop", {63'b0, out_valid}, 64'd0);
        chk("R9 hit gated", {63'b0, out_hit}, 64'd0);
        chk("R7 hold", out_result, 64'h00000000_12345678);

        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        chk("R8 mid reset result", out_result, 64'd0);
        chk("R8 mid reset dst", {59'b0, out_dst}, 64'd0);

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog: actual hung expected done");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule